// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps recent virtual-page to physical-frame pairings so that a memory access to a page seen before can be translated without walking the page tables. A lookup presents a 20-bit virtual page number. One clock later the block returns a hit flag, the 20-bit physical frame number and four attribute bits stored with the pairing. When a lookup misses, the table walker that sits outside this block delivers the pairing through a fill port. The block places it in one of four ways of the set chosen by the low page-number bits.

Writing the page-directory base register pulses a flush input, which invalidates every cached pairing in one cycle. A separate enable input makes entries marked global survive such a flush. Replacement first uses an empty way of the set, then a tree pseudo-LRU victim kept per set. A fill for a page already present in the set rewrites that same way, so no page is ever held twice.

Top module: `xlat_buffer`

## Requirements
- R1: After reset no entry is valid, rsp_valid and rsp_hit are low, and every lookup misses until a fill is made.
- R2: A lookup raised in cycle N gives rsp_valid high in cycle N+1. On a hit, rsp_pfn and rsp_attr show the stored frame and attributes. The set is vpn[3:0] and the tag is vpn[19:4]. Attribute bits are [0] writable, [1] user, [2] dirty, [3] global. A cycle without a lookup gives rsp_valid low in the next cycle.
- R3: A lookup that misses returns rsp_hit low with rsp_pfn and rsp_attr all zero.
- R4: A fill written in cycle N is seen by lookups from cycle N+1 on. A lookup in cycle N itself sees the earlier contents.
- R5: A fill to a set with an empty way uses the lowest-numbered empty way, so no valid entry is evicted.
- R6: A fill to a full set replaces the way named by that set's 3-bit tree. Root bit 0 picks the half: 0 means ways 0/1 under bit 1, 1 means ways 2/3 under bit 2. Each lookup hit and each fill turns the bits on that way's path to point away from it. A lookup hit is applied before a fill in the same cycle. The tree resets to 000.
- R7: A fill whose page is already held in its set overwrites that way, and the other ways of the set are untouched.
- R8: A flush with keep_global low invalidates every entry in the following cycle.
- R9: A flush with keep_global high invalidates only entries whose global attribute bit is clear.
- R10: A fill in the same cycle as a flush is kept valid after the flush. The way for that fill is chosen from the contents held before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| rsp_valid | output | 1 | Lookup response valid (one cycle after request) |
| rsp_hit | output | 1 | Translation found |
| rsp_pfn | output | 20 | Physical frame number (zero on miss) |
| rsp_attr | output | 4 | Stored attributes {global, dirty, user, writable} (zero on miss) |
| fill_en | input | 1 | Write a pairing from the walker |
| fill_vpn | input | 20 | Virtual page number of the pairing |
| fill_pfn | input | 20 | Physical frame number of the pairing |
| fill_attr | input | 4 | Attributes of the pairing |
| dirbase_wr | input | 1 | Directory-base write: flush |
| keep_global | input | 1 | Global entries survive a flush |

## Verification
The assertions check these rules in every cycle: the response appears exactly one cycle after a request, and a miss carries zero data. At most one way hits, and at most one way matches a fill. A flush without the global exemption leaves every valid bit clear. Each per-set tree, once updated, never names the way it was just updated for. Which way is evicted, the survival of global entries, duplicate handling and the same-cycle ordering of fill, lookup and flush can only be seen in the bench scenarios. There a reference model follows the set contents and the tree bits over long random runs and directed corner sequences.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int ATTR_W     = 4;
   localparam int ATTR_WR    = 0;
   localparam int ATTR_USER  = 1;
   localparam int ATTR_DIRTY = 2;
   localparam int ATTR_GLOB  = 3;
endpackage

// File: rtl/tlb_plru_tree.sv
module tlb_plru_tree #(
   parameter int WAYS = 4,
   localparam int WB = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_en,
   input  logic [WB-1:0] a_way,
   input  logic          b_en,
   input  logic [WB-1:0] b_way,
   output logic [WB-1:0] victim
);
   initial begin
      assert (WAYS == 2 || WAYS == 4) else $error("tlb_plru_tree: WAYS must be 2 or 4");
   end

   generate
      if (WAYS == 4) begin : g_four
         logic [2:0] bits_q, bits_a, bits_n;

         function automatic logic [2:0] touch4(input logic [2:0] t, input logic [1:0] w);
            logic [2:0] r;
            r = t;
            case (w)
               2'd0:    begin r[0] = 1'b1; r[1] = 1'b1; end
               2'd1:    begin r[0] = 1'b1; r[1] = 1'b0; end
               2'd2:    begin r[0] = 1'b0; r[2] = 1'b1; end
               default: begin r[0] = 1'b0; r[2] = 1'b0; end
            endcase
            return r;
         endfunction

         always_comb begin
            bits_a = a_en ? touch4(bits_q, a_way) : bits_q;
            bits_n = b_en ? touch4(bits_a, b_way) : bits_a;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) bits_q <= '0;
            else        bits_q <= bits_n;
         end

         assign victim = bits_q[0] ? {1'b1, bits_q[2]} : {1'b0, bits_q[1]};
      end else begin : g_two
         logic bit_q, bit_a, bit_n;

         always_comb begin
            bit_a = a_en ? ~a_way[0] : bit_q;
            bit_n = b_en ? ~b_way[0] : bit_a;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_n;
         end

         assign victim = bit_q;
      end
   endgenerate

   // R6
   plru_away_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_en |=> (victim != $past(b_way)));

   // R6
   plru_away_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && !b_en) |=> (victim != $past(a_way)));
endmodule

// File: rtl/tlb_way_bank.sv
module tlb_way_bank #(
   parameter int SET_BITS = 4,
   parameter int TAG_W    = 16,
   parameter int PFN_W    = 20,
   parameter int ATTR_W   = 4,
   parameter int GLOB_BIT = 3,
   localparam int SETS    = 1 << SET_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SET_BITS-1:0] lk_idx,
   output logic                lk_valid,
   output logic [TAG_W-1:0]    lk_tag,
   output logic [PFN_W-1:0]    lk_pfn,
   output logic [ATTR_W-1:0]   lk_attr,
   input  logic [SET_BITS-1:0] wr_idx,
   output logic                wr_valid,
   output logic [TAG_W-1:0]    wr_tag_q,
   input  logic                wr_en,
   input  logic [TAG_W-1:0]    wr_tag,
   input  logic [PFN_W-1:0]    wr_pfn,
   input  logic [ATTR_W-1:0]   wr_attr,
   input  logic                flush,
   input  logic                keep_global
);
   initial begin
      assert (GLOB_BIT >= 0 && GLOB_BIT < ATTR_W) else $error("tlb_way_bank: GLOB_BIT out of range");
   end

   logic [SETS-1:0]   valid_q, valid_n;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [PFN_W-1:0]  pfn_q  [SETS];
   logic [ATTR_W-1:0] attr_q [SETS];

   always_comb begin
      for (int s = 0; s < SETS; s++) begin
         valid_n[s] = valid_q[s];
         if (flush && !(keep_global && attr_q[s][GLOB_BIT])) valid_n[s] = 1'b0;
         if (wr_en && (int'(wr_idx) == s))                   valid_n[s] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) valid_q <= '0;
      else        valid_q <= valid_n;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         pfn_q[wr_idx]  <= wr_pfn;
         attr_q[wr_idx] <= wr_attr;
      end
   end

   assign lk_valid = valid_q[lk_idx];
   assign lk_tag   = tag_q[lk_idx];
   assign lk_pfn   = pfn_q[lk_idx];
   assign lk_attr  = attr_q[lk_idx];
   assign wr_valid = valid_q[wr_idx];
   assign wr_tag_q = tag_q[wr_idx];

   // R8
   flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !keep_global && !wr_en) |=> (valid_q == '0));

   // R10
   fill_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
   import tlb_pkg::*;
#(
   parameter int VPN_W    = 20,
   parameter int PFN_W    = 20,
   parameter int SET_BITS = 4,
   parameter int WAYS     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PFN_W-1:0]  rsp_pfn,
   output logic [ATTR_W-1:0] rsp_attr,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [ATTR_W-1:0] fill_attr,
   input  logic              dirbase_wr,
   input  logic              keep_global
);
   localparam int SETS  = 1 << SET_BITS;
   localparam int TAG_W = VPN_W - SET_BITS;
   localparam int WB    = (WAYS > 1) ? $clog2(WAYS) : 1;

   initial begin
      assert (SET_BITS >= 1 && SET_BITS < VPN_W) else $error("xlat_buffer: bad SET_BITS");
      assert (WAYS == 2 || WAYS == 4) else $error("xlat_buffer: WAYS must be 2 or 4");
   end

   logic [SET_BITS-1:0] lk_idx, fill_idx;
   logic [TAG_W-1:0]    lk_tag, fill_tag;

   assign lk_idx   = lk_vpn[SET_BITS-1:0];
   assign lk_tag   = lk_vpn[VPN_W-1:SET_BITS];
   assign fill_idx = fill_vpn[SET_BITS-1:0];
   assign fill_tag = fill_vpn[VPN_W-1:SET_BITS];

   logic                wy_lk_v    [WAYS];
   logic [TAG_W-1:0]    wy_lk_t    [WAYS];
   logic [PFN_W-1:0]    wy_lk_pfn  [WAYS];
   logic [ATTR_W-1:0]   wy_lk_attr [WAYS];
   logic                wy_fl_v    [WAYS];
   logic [TAG_W-1:0]    wy_fl_t    [WAYS];
   logic [WAYS-1:0]     hit_vec, dup_vec, inv_vec, wr_vec;
   logic [WB-1:0]       fill_way, hit_way;
   logic [WB-1:0]       set_victim [SETS];

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         tlb_way_bank #(
            .SET_BITS (SET_BITS),
            .TAG_W    (TAG_W),
            .PFN_W    (PFN_W),
            .ATTR_W   (ATTR_W),
            .GLOB_BIT (ATTR_GLOB)
         ) i_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .lk_idx      (lk_idx),
            .lk_valid    (wy_lk_v[w]),
            .lk_tag      (wy_lk_t[w]),
            .lk_pfn      (wy_lk_pfn[w]),
            .lk_attr     (wy_lk_attr[w]),
            .wr_idx      (fill_idx),
            .wr_valid    (wy_fl_v[w]),
            .wr_tag_q    (wy_fl_t[w]),
            .wr_en       (wr_vec[w]),
            .wr_tag      (fill_tag),
            .wr_pfn      (fill_pfn),
            .wr_attr     (fill_attr),
            .flush       (dirbase_wr),
            .keep_global (keep_global)
         );

         assign hit_vec[w] = lk_req && wy_lk_v[w] && (wy_lk_t[w] == lk_tag);
         assign dup_vec[w] = wy_fl_v[w] && (wy_fl_t[w] == fill_tag);
         assign inv_vec[w] = !wy_fl_v[w];
         assign wr_vec[w]  = fill_en && (fill_way == WB'(w));
      end

      for (genvar s = 0; s < SETS; s++) begin : g_set
         logic upd_hit, upd_fill;
         assign upd_hit  = (|hit_vec) && (lk_idx == SET_BITS'(s));
         assign upd_fill = fill_en && (fill_idx == SET_BITS'(s));

         tlb_plru_tree #(.WAYS(WAYS)) i_plru (
            .clk    (clk),
            .rst_n  (rst_n),
            .a_en   (upd_hit),
            .a_way  (hit_way),
            .b_en   (upd_fill),
            .b_way  (fill_way),
            .victim (set_victim[s])
         );
      end
   endgenerate

   logic [PFN_W-1:0]  hit_pfn;
   logic [ATTR_W-1:0] hit_attr;

   always_comb begin
      hit_pfn  = '0;
      hit_attr = '0;
      hit_way  = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) begin
            hit_pfn  = hit_pfn  | wy_lk_pfn[w];
            hit_attr = hit_attr | wy_lk_attr[w];
            hit_way  = hit_way  | WB'(w);
         end
      end
   end

   logic [WB-1:0] dup_way, inv_way;

   always_comb begin
      dup_way = '0;
      inv_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (dup_vec[w]) dup_way = WB'(w);
         if (inv_vec[w]) inv_way = WB'(w);
      end
      if (|dup_vec)      fill_way = dup_way;
      else if (|inv_vec) fill_way = inv_way;
      else               fill_way = set_victim[fill_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_pfn   <= '0;
         rsp_attr  <= '0;
      end else begin
         rsp_valid <= lk_req;
         rsp_hit   <= |hit_vec;
         rsp_pfn   <= hit_pfn;
         rsp_attr  <= hit_attr;
      end
   end

   // R2
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> rsp_valid);

   // R2
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !rsp_valid);

   // R3
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0 && rsp_attr == '0));

   // R7
   single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R7
   single_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dup_vec));
endmodule

// File: tb/test_xlat_buffer.sv
module test_xlat_buffer;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_req;
   logic [19:0] lk_vpn;
   logic        rsp_valid, rsp_hit;
   logic [19:0] rsp_pfn;
   logic [3:0]  rsp_attr;
   logic        fill_en;
   logic [19:0] fill_vpn, fill_pfn;
   logic [3:0]  fill_attr;
   logic        dirbase_wr, keep_global;

   always #5 clk = ~clk;

   xlat_buffer i_xlat_buffer (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_attr(rsp_attr),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_attr(fill_attr),
      .dirbase_wr(dirbase_wr), .keep_global(keep_global)
   );

   int checks = 0;
   int failures = 0;

   bit          m_v    [16][4];
   logic [15:0] m_tag  [16][4];
   logic [19:0] m_pfn  [16][4];
   logic [3:0]  m_attr [16][4];
   logic [2:0]  m_plru [16];

   function automatic int m_victim(logic [2:0] b);
      if (b[0]) return b[2] ? 3 : 2;
      return b[1] ? 1 : 0;
   endfunction

   function automatic logic [2:0] m_touch(logic [2:0] b, int w);
      logic [2:0] r = b;
      case (w)
         0: begin r[0] = 1; r[1] = 1; end
         1: begin r[0] = 1; r[1] = 0; end
         2: begin r[0] = 0; r[2] = 1; end
         default: begin r[0] = 0; r[2] = 0; end
      endcase
      return r;
   endfunction

   task automatic chk(string r, logic [25:0] got, logic [25:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %h expected %h", r, got, exp);
      end
   endtask

   task automatic step(bit req, logic [19:0] vpn, bit fe, logic [19:0] fvpn,
                       logic [19:0] fpfn, logic [3:0] fattr, bit fl, bit kg,
                       string r, int exp_hit);
      int s, fs, hw, fw;
      bit hit;
      logic [25:0] exp;
      lk_req = req; lk_vpn = vpn; fill_en = fe; fill_vpn = fvpn;
      fill_pfn = fpfn; fill_attr = fattr; dirbase_wr = fl; keep_global = kg;
      s = int'(vpn[3:0]);
      hit = 0; hw = 0;
      exp = '0;
      for (int w = 0; w < 4; w++)
         if (m_v[s][w] && m_tag[s][w] == vpn[19:4]) begin hit = 1; hw = w; end
      if (req) exp = {1'b1, hit, hit ? m_pfn[s][hw] : 20'h0, hit ? m_attr[s][hw] : 4'h0};
      fs = int'(fvpn[3:0]);
      fw = -1;
      for (int w = 0; w < 4; w++)
         if (m_v[fs][w] && m_tag[fs][w] == fvpn[19:4]) fw = w;
      if (fw < 0)
         for (int w = 3; w >= 0; w--) if (!m_v[fs][w]) fw = w;
      if (fw < 0) fw = m_victim(m_plru[fs]);
      if (req && hit) m_plru[s] = m_touch(m_plru[s], hw);
      if (fe) m_plru[fs] = m_touch(m_plru[fs], fw);
      if (fl)
         for (int a = 0; a < 16; a++)
            for (int w = 0; w < 4; w++)
               if (!(kg && m_attr[a][w][3])) m_v[a][w] = 0;
      if (fe) begin
         m_v[fs][fw] = 1; m_tag[fs][fw] = fvpn[19:4];
         m_pfn[fs][fw] = fpfn; m_attr[fs][fw] = fattr;
      end
      @(negedge clk);
      chk(r, {rsp_valid, rsp_hit, rsp_pfn, rsp_attr}, exp);
      if (exp_hit >= 0) chk({r, " directed"}, {25'h0, rsp_hit}, {25'h0, exp_hit[0]});
   endtask

   task automatic look(logic [19:0] vpn, string r, int exp_hit);
      step(1, vpn, 0, '0, '0, '0, 0, 0, r, exp_hit);
   endtask

   task automatic fill(logic [19:0] vpn, logic [19:0] pfn, logic [3:0] attr, string r);
      step(0, '0, 1, vpn, pfn, attr, 0, 0, r, -1);
   endtask

   function automatic logic [19:0] pg(int tag, int set);
      return {16'(tag), 4'(set)};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250611));
      for (int a = 0; a < 16; a++) begin
         m_plru[a] = '0;
         for (int w = 0; w < 4; w++) begin
            m_v[a][w] = 0; m_tag[a][w] = '0; m_pfn[a][w] = '0; m_attr[a][w] = '0;
         end
      end
      rst_n = 0; lk_req = 0; lk_vpn = '0; fill_en = 0; fill_vpn = '0;
      fill_pfn = '0; fill_attr = '0; dirbase_wr = 0; keep_global = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset", {rsp_valid, rsp_hit, 24'h0}, 26'h0);
      look(pg(1, 0), "R1 empty lookup", 0);
      look(pg(9, 15), "R1 empty lookup", 0);

      // R4 fill and same-cycle lookup
      step(1, 20'h12345, 1, 20'h12345, 20'hABCDE, 4'b0101, 0, 0, "R4 same cycle", 0);
      look(20'h12345, "R2 hit after fill", 1);
      look(20'h12355, "R3 miss other tag", 0);

      // R5 empty ways used first
      fill(pg(1, 7), 20'h00071, 4'h1, "R5 fill");
      fill(pg(2, 7), 20'h00072, 4'h2, "R5 fill");
      fill(pg(3, 7), 20'h00073, 4'h4, "R5 fill");
      fill(pg(4, 7), 20'h00074, 4'h8, "R5 fill");
      for (int t = 1; t <= 4; t++) look(pg(t, 7), "R5 all kept", 1);

      // R6 pseudo-LRU victim: after A..D and a hit on A, C is evicted
      for (int t = 1; t <= 4; t++) fill(pg(t, 3), 20'h30000 + 20'(t), 4'h3, "R6 fill");
      look(pg(1, 3), "R6 touch A", 1);
      fill(pg(5, 3), 20'h30005, 4'h3, "R6 fill E");
      look(pg(1, 3), "R6 A kept", 1);
      look(pg(2, 3), "R6 B kept", 1);
      look(pg(3, 3), "R6 C evicted", 0);
      look(pg(4, 3), "R6 D kept", 1);
      look(pg(5, 3), "R6 E present", 1);

      // R7 duplicate fill overwrites
      fill(pg(2, 3), 20'h3BBBB, 4'h7, "R7 refill B");
      look(pg(2, 3), "R7 new data", 1);
      look(pg(1, 3), "R7 A untouched", 1);
      look(pg(4, 3), "R7 D untouched", 1);
      look(pg(5, 3), "R7 E untouched", 1);

      // R8 full flush
      step(0, '0, 0, '0, '0, '0, 1, 0, "R8 flush", -1);
      look(pg(1, 3), "R8 after flush", 0);
      look(20'h12345, "R8 after flush", 0);

      // R9 global entries survive when enabled
      fill(pg(6, 9), 20'h99999, 4'b1000, "R9 fill global");
      fill(pg(7, 9), 20'h88888, 4'b0001, "R9 fill local");
      step(0, '0, 0, '0, '0, '0, 1, 1, "R9 flush keep", -1);
      look(pg(6, 9), "R9 global kept", 1);
      look(pg(7, 9), "R9 local gone", 0);
      step(0, '0, 0, '0, '0, '0, 1, 0, "R9 flush all", -1);
      look(pg(6, 9), "R9 global gone", 0);

      // R10 fill concurrent with flush
      fill(pg(1, 2), 20'h22221, 4'h0, "R10 pre");
      step(0, '0, 1, pg(2, 2), 20'h22222, 4'h0, 1, 0, "R10 fill+flush", -1);
      look(pg(2, 2), "R10 fill kept", 1);
      look(pg(1, 2), "R10 old flushed", 0);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         bit rq, fe, fl, kg;
         rq = ($urandom_range(0, 99) < 65);
         fe = ($urandom_range(0, 99) < 30);
         fl = ($urandom_range(0, 99) < 2);
         kg = $urandom_range(0, 1);
         step(rq, pg($urandom_range(0, 7), $urandom_range(0, 3)), fe,
              pg($urandom_range(0, 7), $urandom_range(0, 3)),
              20'($urandom), 4'($urandom), fl, kg, "R2/R6/R9 random", -1);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule